// File: doc/BRIEF.md
# Sync-Relative Clamp and Sync Pulse Generator

This block runs in the pixel clock domain and watches an incoming horizontal sync. From that sync it derives two timed pulses. The first is a clamp window: it opens a programmed number of pixel periods after the sync trailing edge and stays open for a programmed number of pixel periods. The second is a regenerated horizontal sync of programmable width, launched from the incoming leading edge.

A select input lets an external clamp signal bypass the internal window timing. When the select is set, the clamp output follows the external clamp input combinationally, and the window length has no effect on the output. The incoming sync passes through two flops before its edges are detected. A window length of zero is not a legal setting, and this design treats it as a length of one.

Top module: `sync_clamp_gen`

## Requirements
- R1: A synchronous active-high reset clears every counter. From the clock edge that samples `rst` high, `hsync_out` and the internal clamp window are both 0.
- R2: Let E0 be the first rising clock edge that samples `hsync_in` high after it was low. `hsync_out` rises after edge E0+1.
- R3: With `sync_width` = W and 1 <= W <= 255, `hsync_out` stays high for exactly W pixel clock cycles, after edges E0+1 through E0+W.
- R4: With `sync_width` = 0, a sync leading edge produces no `hsync_out` pulse.
- R5: With `clamp_ext_sel` = 0, let F0 be the first rising edge that samples `hsync_in` low after it was high. With `clamp_delay` = P (0 to 255), `clamp_out` rises after edge F0+1+P.
- R6: With `clamp_len` = L and 1 <= L <= 255, the internal clamp stays high for exactly L cycles.
- R7: `clamp_len` = 0 is treated as 1, so the window lasts one cycle.
- R8: A new sync trailing edge restarts the placement count, even while a window is open or waiting. At edge F0'+1 the clamp drops (when P > 0), and a fresh window of full length opens after edge F0'+1+P.
- R9: With `clamp_ext_sel` = 1, `clamp_out` equals `clamp_ext` in the same cycle. `clamp_len`, `clamp_delay` and the sync timing then have no effect on `clamp_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_in | input | 1 | Incoming horizontal sync, active high |
| clamp_ext | input | 1 | External clamp signal |
| clamp_ext_sel | input | 1 | 1 selects the external clamp, 0 selects the internal window |
| clamp_delay | input | 8 | Pixel periods from the sync trailing edge to the start of the window |
| clamp_len | input | 8 | Window length in pixel periods (0 treated as 1) |
| sync_width | input | 8 | Regenerated sync width in pixel periods (0 means no pulse) |
| clamp_out | output | 1 | Clamp window output |
| hsync_out | output | 1 | Regenerated horizontal sync |

## Verification
Directed lines use placement and length values of 0, 1 and 255. These separate off-by-one errors at each end of both counters, and they isolate the zero-length substitution. Random lines mix sync high times that are shorter and longer than the regenerated width. This shows that the leading-edge and trailing-edge timers run independently. A second sync pulse placed inside an open window tells a restart of the placement apart from a window that simply runs to its end. An external-select run toggles the external clamp while a maximum-length internal window is pending, to show that the internal path is masked.

// File: rtl/sync_clamp_pkg.sv
package sync_clamp_pkg;

    typedef enum logic [1:0] {
        CLP_IDLE = 2'd0,
        CLP_WAIT = 2'd1,
        CLP_ON   = 2'd2
    } clp_state_e;

    typedef struct packed {
        logic stage1;
        logic stage2;
    } edge_regs_t;

endpackage

// File: rtl/sync_edge_det.sv
module sync_edge_det
    import sync_clamp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sync_in,
    output logic rise,
    output logic fall
);

    edge_regs_t ed_d, ed_q;

    always_comb begin
        ed_d        = ed_q;
        ed_d.stage1 = sync_in;
        ed_d.stage2 = ed_q.stage1;
    end

    always_ff @(posedge clk) begin
        if (rst) ed_q <= '0;
        else     ed_q <= ed_d;
    end

    assign rise = ed_q.stage1 & ~ed_q.stage2;
    assign fall = ~ed_q.stage1 & ed_q.stage2;

endmodule

// File: rtl/clamp_timer.sv
module clamp_timer
    import sync_clamp_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] delay,
    input  logic [CNT_W-1:0] len,
    output logic             active
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        clp_state_e       state;
        logic [CNT_W-1:0] cnt;
    } clp_regs_t;

    clp_regs_t        ct_d, ct_q;
    logic [CNT_W-1:0] len_eff;

    // zero length is illegal; it is substituted by one
    assign len_eff = (len == '0) ? ONE : len;

    always_comb begin
        ct_d = ct_q;
        unique case (ct_q.state)
            CLP_WAIT: begin
                if (ct_q.cnt <= ONE) begin
                    ct_d.state = CLP_ON;
                    ct_d.cnt   = len_eff;
                end else begin
                    ct_d.cnt = ct_q.cnt - ONE;
                end
            end
            CLP_ON: begin
                if (ct_q.cnt <= ONE) begin
                    ct_d.state = CLP_IDLE;
                    ct_d.cnt   = '0;
                end else begin
                    ct_d.cnt = ct_q.cnt - ONE;
                end
            end
            default: begin
                ct_d.state = CLP_IDLE;
                ct_d.cnt   = '0;
            end
        endcase
        // a trailing edge always restarts the placement
        if (start) begin
            if (delay == '0) begin
                ct_d.state = CLP_ON;
                ct_d.cnt   = len_eff;
            end else begin
                ct_d.state = CLP_WAIT;
                ct_d.cnt   = delay;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ct_q.state <= CLP_IDLE;
            ct_q.cnt   <= '0;
        end else begin
            ct_q <= ct_d;
        end
    end

    assign active = (ct_q.state == CLP_ON);

endmodule

// File: rtl/sync_regen.sv
module sync_regen #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] width,
    output logic             pulse
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic             on;
        logic [CNT_W-1:0] cnt;
    } rg_regs_t;

    rg_regs_t rg_d, rg_q;

    always_comb begin
        rg_d = rg_q;
        if (rg_q.on) begin
            if (rg_q.cnt <= ONE) begin
                rg_d.on  = 1'b0;
                rg_d.cnt = '0;
            end else begin
                rg_d.cnt = rg_q.cnt - ONE;
            end
        end
        if (start) begin
            rg_d.on  = (width != '0);
            rg_d.cnt = width;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rg_q <= '0;
        else     rg_q <= rg_d;
    end

    assign pulse = rg_q.on;

endmodule

// File: rtl/sync_clamp_gen.sv
module sync_clamp_gen #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hsync_in,
    input  logic             clamp_ext,
    input  logic             clamp_ext_sel,
    input  logic [CNT_W-1:0] clamp_delay,
    input  logic [CNT_W-1:0] clamp_len,
    input  logic [CNT_W-1:0] sync_width,
    output logic             clamp_out,
    output logic             hsync_out
);

    logic sync_rise;
    logic sync_fall;
    logic clamp_int;

    sync_edge_det u_edge (
        .clk     (clk),
        .rst     (rst),
        .sync_in (hsync_in),
        .rise    (sync_rise),
        .fall    (sync_fall)
    );

    clamp_timer #(.CNT_W(CNT_W)) u_clamp (
        .clk    (clk),
        .rst    (rst),
        .start  (sync_fall),
        .delay  (clamp_delay),
        .len    (clamp_len),
        .active (clamp_int)
    );

    sync_regen #(.CNT_W(CNT_W)) u_regen (
        .clk   (clk),
        .rst   (rst),
        .start (sync_rise),
        .width (sync_width),
        .pulse (hsync_out)
    );

    assign clamp_out = clamp_ext_sel ? clamp_ext : clamp_int;

endmodule

// File: rtl/sync_clamp_gen_chk.sv
module sync_clamp_gen_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             clamp_ext,
    input logic             clamp_ext_sel,
    input logic [CNT_W-1:0] sync_width,
    input logic             sync_rise,
    input logic             clamp_int,
    input logic             clamp_out,
    input logic             hsync_out
);

    localparam int RUN_W   = CNT_W + 1;
    localparam int MAX_LEN = (1 << CNT_W) - 1;
    localparam logic [RUN_W-1:0] RUN_SAT = '1;

    logic [RUN_W-1:0] clamp_run;
    logic [RUN_W-1:0] hs_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            clamp_run <= '0;
            hs_run    <= '0;
        end else begin
            clamp_run <= !clamp_int ? '0 : (clamp_run == RUN_SAT ? clamp_run : clamp_run + 1'b1);
            hs_run    <= !hsync_out ? '0 : (hs_run == RUN_SAT ? hs_run : hs_run + 1'b1);
        end
    end

    // R1
    rst_hs_chk: assert property (@(posedge clk) rst |=> !hsync_out);

    // R1
    rst_clamp_chk: assert property (@(posedge clk) rst |=> !clamp_int);

    // R2
    hs_launch_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(hsync_out) |-> $past(sync_rise));

    // R4
    hs_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(hsync_out) |-> ($past(sync_width) != '0));

    // R3
    hs_len_max_chk: assert property (@(posedge clk) disable iff (rst)
        int'(hs_run) <= MAX_LEN);

    // R6
    clamp_len_max_chk: assert property (@(posedge clk) disable iff (rst)
        int'(clamp_run) <= MAX_LEN);

    // R9
    ext_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (clamp_ext_sel && $past(clamp_ext_sel) && $stable(clamp_ext)) |-> $stable(clamp_out));

endmodule

bind sync_clamp_gen sync_clamp_gen_chk #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .clamp_ext     (clamp_ext),
    .clamp_ext_sel (clamp_ext_sel),
    .sync_width    (sync_width),
    .sync_rise     (sync_rise),
    .clamp_int     (clamp_int),
    .clamp_out     (clamp_out),
    .hsync_out     (hsync_out)
);

// File: tb/tb_sync_clamp_gen.sv
`timescale 1ns/1ps
module tb_sync_clamp_gen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hsync_in = 1'b0;
    logic       clamp_ext = 1'b0;
    logic       clamp_ext_sel = 1'b0;
    logic [7:0] clamp_delay = 8'd0;
    logic [7:0] clamp_len = 8'd1;
    logic [7:0] sync_width = 8'd0;
    logic       clamp_out;
    logic       hsync_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    sync_clamp_gen dut (
        .clk           (clk),
        .rst           (rst),
        .hsync_in      (hsync_in),
        .clamp_ext     (clamp_ext),
        .clamp_ext_sel (clamp_ext_sel),
        .clamp_delay   (clamp_delay),
        .clamp_len     (clamp_len),
        .sync_width    (sync_width),
        .clamp_out     (clamp_out),
        .hsync_out     (hsync_out)
    );

    // sample s is taken after edge E0+s-1; R2/R3: high for s in [2, W+1]
    function automatic bit exp_hs(int s, int w);
        return (w != 0) && (s >= 2) && (s <= w + 1);
    endfunction

    function automatic int eff_len(int l);
        return (l == 0) ? 1 : l;
    endfunction

    // R5/R6/R7: trailing edge at E0+h, high for s in [h+p+2, h+p+Leff+1]
    function automatic bit exp_clamp(int s, int h, int p, int l);
        return (s >= h + p + 2) && (s <= h + p + eff_len(l) + 1);
    endfunction

    task automatic check_bit(string req, int s, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s sample %0d: actual %b expected %b", req, s, act, exp);
        end
    endtask

    task automatic run_line(int h, int p, int l, int w, string req);
        int total;
        @(negedge clk);
        clamp_delay = 8'(p);
        clamp_len   = 8'(l);
        sync_width  = 8'(w);
        hsync_in    = 1'b1;
        total = (w + 3 > h + p + eff_len(l) + 4) ? w + 3 : h + p + eff_len(l) + 4;
        for (int s = 1; s <= total; s++) begin
            @(negedge clk);
            check_bit({req, " hsync_out"}, s, hsync_out, exp_hs(s, w));
            check_bit({req, " clamp_out"}, s, clamp_out, exp_clamp(s, h, p, l));
            if (s == h) hsync_in = 1'b0;
        end
    endtask

    // R8: second trailing edge at sample 20 restarts the window
    task automatic run_restart();
        int h, p, l, b, a;
        bit e;
        h = 3; p = 10; l = 20; b = 18; a = 20;
        @(negedge clk);
        clamp_delay = 8'(p);
        clamp_len   = 8'(l);
        sync_width  = 8'd4;
        hsync_in    = 1'b1;
        for (int s = 1; s <= a + p + l + 5; s++) begin
            @(negedge clk);
            e = ((s >= h + p + 2) && (s <= a + 1)) ||
                ((s >= a + p + 2) && (s <= a + p + l + 1));
            check_bit("R8 restart clamp_out", s, clamp_out, e);
            if (s == h) hsync_in = 1'b0;
            if (s == b) hsync_in = 1'b1;
            if (s == a) hsync_in = 1'b0;
        end
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check_bit("R1 reset hsync_out", 0, hsync_out, 1'b0);
        check_bit("R1 reset clamp_out", 0, clamp_out, 1'b0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // directed corners
        run_line(4, 0, 1, 1, "R2 R3 R5 R6 min");
        run_line(2, 1, 1, 3, "R5 R6 p1");
        run_line(5, 3, 0, 2, "R7 len zero");
        run_line(6, 2, 5, 0, "R4 width zero");
        run_line(3, 255, 2, 255, "R3 R5 max");
        run_line(2, 1, 255, 7, "R6 len max");
        run_line(40, 4, 9, 10, "R3 long sync");

        run_restart();

        // R1: reset in the middle of a pulse and a pending window
        @(negedge clk);
        sync_width  = 8'd50;
        clamp_delay = 8'd0;
        clamp_len   = 8'd50;
        hsync_in    = 1'b1;
        repeat (4) @(negedge clk);
        hsync_in = 1'b0;
        repeat (4) @(negedge clk);
        check_bit("R1 pre-reset hsync_out", 0, hsync_out, 1'b1);
        check_bit("R1 pre-reset clamp_out", 0, clamp_out, 1'b1);
        rst = 1'b1;
        @(negedge clk);
        check_bit("R1 mid reset hsync_out", 0, hsync_out, 1'b0);
        check_bit("R1 mid reset clamp_out", 0, clamp_out, 1'b0);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        check_bit("R1 post reset hsync_out", 0, hsync_out, 1'b0);
        check_bit("R1 post reset clamp_out", 0, clamp_out, 1'b0);

        // R9: external select with an internal window pending
        @(negedge clk);
        clamp_ext_sel = 1'b1;
        clamp_delay   = 8'd2;
        clamp_len     = 8'd255;
        hsync_in      = 1'b1;
        for (int k = 0; k < 60; k++) begin
            if (k == 3) hsync_in = 1'b0;
            clamp_ext = 1'($urandom_range(0, 1));
            #1;
            check_bit("R9 ext follow", k, clamp_out, clamp_ext);
            @(negedge clk);
            check_bit("R9 ext hold", k, clamp_out, clamp_ext);
        end
        clamp_ext = 1'b0;
        repeat (300) @(negedge clk);
        clamp_ext_sel = 1'b0;
        @(negedge clk);
        check_bit("R9 internal idle after ext", 0, clamp_out, 1'b0);

        // random lines
        for (int i = 0; i < 40; i++) begin
            run_line(int'($urandom_range(1, 30)), int'($urandom_range(0, 40)),
                     int'($urandom_range(0, 60)), int'($urandom_range(0, 40)),
                     "R2 R3 R5 R6 random");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule